// File: doc/BRIEF.md
# Banked GPIO Pad Controller with Per-Pin Event Detection

This block manages a bank of general-purpose pads behind a plain 32-bit register port (address, write strobe, write data, combinational read data). Every pad owns one configuration word. That word holds the value driven onto the pad, a read-only copy of the synchronised pad input, an input-inversion flag and a two-bit field that picks how the pad raises events: level, one edge or both edges.

Events land in sticky status bits, with 32 pads packed into each status word. Software clears a status bit by writing a one to it. A matching bank of enable words masks each pad. One interrupt line is high while any pad has both its status bit and its enable bit set. The pad count is a parameter and goes up to 128. The default is 80.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Pad n's configuration word is at byte address 0x600 + 16*n. Its bit 0 is read/write and drives pad_out[n]. Writable bits are 0, 23, 26 and 25. All other bits read 0.
- R2: Configuration bit 1 reads pad_in[n] through a two-stage synchroniser. A change sampled at one clock edge is visible after the second edge. Writes to bit 1 have no effect.
- R3: Configuration bit 23 set inverts the synchronised input before event detection. This gives active-low detection.
- R4: Event field bits 26:25 = 00 is level mode. The status bit is set on every cycle the possibly inverted input is 1, so a clear written while that input stays 1 does not stick.
- R5: Event field = 01 sets the status bit only on a 0-to-1 change of the possibly inverted input.
- R6: Event field = 11 sets the status bit on either change. Event field = 10 produces no events.
- R7: Status words are at 0x100 + 4*k, and pad n maps to word n/32, bit n%32. Writing 1 to a bit clears it and writing 0 leaves it alone. An event in the same cycle as a clear wins.
- R8: Enable words are at 0x110 + 4*k with the same packing. They are read/write and reset to 0.
- R9: irq is 1 exactly when some status bit and its enable bit are both 1.
- R10: Addresses that match no register read 0 and ignore writes. This covers config offsets that are not 16-aligned, pads at or beyond the pad count, and words beyond the last. Status and enable bits of absent pads read 0.
- R11: After reset, every configuration word is 0, every status bit is 0 (with inputs low) and pad_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wr | input | 1 | Write strobe, sampled at rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS (80) | Asynchronous pad inputs |
| pad_out | output | NUM_PINS (80) | Pad output drive values |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives falling and rising inputs in each event mode, both plain and inverted.

- A detector that confused the edge direction, or ignored the inversion flag, would set status on the wrong transition.
- A detector whose disabled mode still fired would also set status on the wrong transition.

Several cases target the status and enable words:

- A clear written while a level input stays active must not stick.
- A write of zero to a status word must change nothing.
- Either fault would leave a wrong status word.
- An interrupt that ignored the enable mask would rise early.

The bench also probes synchroniser latency. It reads the input bit after one edge and again after two, so a single-stage or three-stage chain shows up at once.

It reads and writes off-map addresses and the absent bits of the last word. A decoder that aliased would return data there.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
   localparam int WORD_W   = 32;
   localparam int TX_BIT   = 0;
   localparam int RX_BIT   = 1;
   localparam int INV_BIT  = 23;
   localparam int MODE_LSB = 25;

   typedef enum logic [1:0] {
      EV_LEVEL = 2'b00,
      EV_EDGE  = 2'b01,
      EV_OFF   = 2'b10,
      EV_BOTH  = 2'b11
   } ev_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
   import gpio_pad_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pad_i,
   input  logic              cfg_we,
   input  logic              cfg_tx,
   input  logic              cfg_inv,
   input  logic [1:0]        cfg_mode,
   input  logic              sts_clr,
   output logic              pad_o,
   output logic [WORD_W-1:0] cfg_word_o,
   output logic              sts_o
);
   logic     rx_s;
   logic     tx_q, inv_q, prev_q, sts_q;
   ev_mode_e mode_q;
   logic     cur, evt;

   gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_i),
      .q    (rx_s)
   );

   assign cur = rx_s ^ inv_q;

   always_comb begin
      unique case (mode_q)
         EV_LEVEL: evt = cur;
         EV_EDGE:  evt = cur & ~prev_q;
         EV_BOTH:  evt = cur ^ prev_q;
         default:  evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= 1'b0;
         inv_q  <= 1'b0;
         mode_q <= EV_LEVEL;
         prev_q <= 1'b0;
         sts_q  <= 1'b0;
      end else begin
         prev_q <= cur;
         sts_q  <= (sts_q & ~sts_clr) | evt;
         if (cfg_we) begin
            tx_q   <= cfg_tx;
            inv_q  <= cfg_inv;
            mode_q <= ev_mode_e'(cfg_mode);
         end
      end
   end

   always_comb begin
      cfg_word_o                        = '0;
      cfg_word_o[TX_BIT]                = tx_q;
      cfg_word_o[RX_BIT]                = rx_s;
      cfg_word_o[INV_BIT]               = inv_q;
      cfg_word_o[MODE_LSB+1:MODE_LSB]   = mode_q;
   end

   assign pad_o = tx_q;
   assign sts_o = sts_q;

   // R7: a clear with no concurrent event leaves the bit low
   a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr && !evt) |=> !sts_o);
   // R7: pending bits stay set until cleared
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o && !sts_clr) |=> sts_o);
   // R4: level mode re-arms on every active cycle
   a_r4_level_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == EV_LEVEL && cur) |=> sts_o);
   // R5: edge mode never sets status without a rising input
   a_r5_edge_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == EV_EDGE && !(cur && !prev_q) && !sts_o) |=> !sts_o);
   // R1: output drive only changes on a configuration write
   a_r1_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(pad_o));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_pad_pkg::*;
#(
   parameter int NUM_PINS    = 80,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_BASE    = 'h600,
   parameter int CFG_STRIDE  = 16,
   parameter int STS_BASE    = 'h100,
   parameter int EN_BASE     = 'h110
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic                irq
);
   localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int STRIDE_LG = $clog2(CFG_STRIDE);
   localparam int IDX_W     = ADDR_W - STRIDE_LG;
   localparam int WIDX_W    = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
   localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + CFG_STRIDE * NUM_PINS);
   localparam logic [ADDR_W-1:0] STS_LO = ADDR_W'(STS_BASE);
   localparam logic [ADDR_W-1:0] STS_HI = ADDR_W'(STS_BASE + 4 * NUM_WORDS);
   localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
   localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * NUM_WORDS);

   if (NUM_PINS < 1 || NUM_PINS > 128) begin : g_bad_pins
      $error("gpio_pad_ctrl: NUM_PINS out of range 1..128");
   end
   if (CFG_STRIDE < 4 || CFG_STRIDE != (1 << STRIDE_LG)) begin : g_bad_stride
      $error("gpio_pad_ctrl: CFG_STRIDE must be a power of two >= 4");
   end
   if (CFG_BASE + CFG_STRIDE * NUM_PINS > (1 << ADDR_W)) begin : g_bad_cfg_span
      $error("gpio_pad_ctrl: configuration window exceeds address space");
   end
   if (STS_BASE + 4 * NUM_WORDS > EN_BASE || EN_BASE + 4 * NUM_WORDS > CFG_BASE) begin : g_bad_overlap
      $error("gpio_pad_ctrl: register windows overlap");
   end

   // Address decode
   logic [ADDR_W-1:0] cfg_off, sts_off, en_off;
   logic              cfg_hit, sts_hit, en_hit;
   logic [IDX_W-1:0]  cfg_idx;
   logic [WIDX_W-1:0] sts_idx, en_idx;

   assign cfg_off = bus_addr - CFG_LO;
   assign sts_off = bus_addr - STS_LO;
   assign en_off  = bus_addr - EN_LO;
   assign cfg_idx = cfg_off[ADDR_W-1:STRIDE_LG];
   assign sts_idx = sts_off[ADDR_W-1:2];
   assign en_idx  = en_off[ADDR_W-1:2];
   assign cfg_hit = (bus_addr >= CFG_LO) && (bus_addr < CFG_HI) && (cfg_off[STRIDE_LG-1:0] == '0);
   assign sts_hit = (bus_addr >= STS_LO) && (bus_addr < STS_HI) && (bus_addr[1:0] == 2'b00);
   assign en_hit  = (bus_addr >= EN_LO)  && (bus_addr < EN_HI)  && (bus_addr[1:0] == 2'b00);

   logic [NUM_PINS-1:0]  cfg_sel, sts_clr, sts_pin;
   logic [WORD_W-1:0]    cfg_words [NUM_PINS];
   logic [NUM_WORDS-1:0] sts_sel, en_sel;
   logic [WORD_W-1:0]    sts_words [NUM_WORDS];
   logic [WORD_W-1:0]    en_q      [NUM_WORDS];

   // Per-pad cells
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      assign cfg_sel[p] = cfg_hit && (cfg_idx == IDX_W'(p));
      assign sts_clr[p] = bus_wr && sts_sel[p / WORD_W] && bus_wdata[p % WORD_W];

      gpio_pad_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .pad_i     (pad_in[p]),
         .cfg_we    (bus_wr && cfg_sel[p]),
         .cfg_tx    (bus_wdata[TX_BIT]),
         .cfg_inv   (bus_wdata[INV_BIT]),
         .cfg_mode  (bus_wdata[MODE_LSB+1:MODE_LSB]),
         .sts_clr   (sts_clr[p]),
         .pad_o     (pad_out[p]),
         .cfg_word_o(cfg_words[p]),
         .sts_o     (sts_pin[p])
      );
   end

   // Banked status packing and enable registers
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int VALID = (NUM_PINS - w * WORD_W > WORD_W) ? WORD_W : NUM_PINS - w * WORD_W;
      localparam logic [WORD_W-1:0] MASK = WORD_W'((64'd1 << VALID) - 64'd1);

      assign sts_sel[w] = sts_hit && (sts_idx == WIDX_W'(w));
      assign en_sel[w]  = en_hit  && (en_idx  == WIDX_W'(w));

      for (genvar b = 0; b < WORD_W; b++) begin : g_bit
         if (b < VALID) begin : g_live
            assign sts_words[w][b] = sts_pin[w * WORD_W + b];
         end else begin : g_absent
            assign sts_words[w][b] = 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   en_q[w] <= '0;
         else if (bus_wr && en_sel[w]) en_q[w] <= bus_wdata & MASK;
      end
   end

   // Read mux and interrupt combine
   logic en_any;
   always_comb begin
      bus_rdata = '0;
      irq       = 1'b0;
      en_any    = 1'b0;
      for (int p = 0; p < NUM_PINS; p++)
         if (cfg_sel[p]) bus_rdata = cfg_words[p];
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (sts_sel[w]) bus_rdata = sts_words[w];
         if (en_sel[w])  bus_rdata = en_q[w];
         irq    = irq | (|(sts_words[w] & en_q[w]));
         en_any = en_any | (|en_q[w]);
      end
   end

   // R9: no interrupt while every pad is masked
   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> en_any);
   // R8: enables only change through a bus write
   a_r8_en_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(en_any));
endmodule

// File: tb/test_gpio_pad_ctrl.sv
`timescale 1ns/1ps
module test_gpio_pad_ctrl;
   localparam int NP = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_pad_ctrl i_gpio_pad_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .irq(irq)
   );

   typedef struct packed {
      int unsigned pin;
      logic [1:0]  mode;
      logic        inv;
      logic        pre;
      logic        post;
      logic        exp;
   } vec_t;

   // pin, mode, inv, input before, input after, expected status
   localparam vec_t VECS [11] = '{
      '{0,  2'b01, 1'b0, 1'b0, 1'b1, 1'b1},   // R5 rise
      '{0,  2'b01, 1'b0, 1'b1, 1'b0, 1'b0},   // R5 fall ignored
      '{5,  2'b01, 1'b1, 1'b1, 1'b0, 1'b1},   // R3 inverted rise
      '{5,  2'b01, 1'b1, 1'b0, 1'b1, 1'b0},   // R3 inverted fall
      '{33, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1},   // R6 both, rise
      '{33, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1},   // R6 both, fall
      '{79, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1},   // R4 level high
      '{79, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1},   // R4 level active-low
      '{40, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},   // R4 level idle
      '{64, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0},   // R6 disabled mode
      '{31, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1}    // R6 both, inverted
   };

   task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic set_pin(input int p, input logic v);
      @(negedge clk);
      pad_in[p] = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [11:0] cfg_a(input int p);
      return 12'h600 + 12'(16 * p);
   endfunction

   function automatic logic [11:0] sts_a(input int p);
      return 12'h100 + 12'(4 * (p / 32));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;

      // Vector table: R3 R4 R5 R6, plus R2 read-back of the input bit
      foreach (VECS[i]) begin
         set_pin(int'(VECS[i].pin), VECS[i].pre);
         wr(cfg_a(int'(VECS[i].pin)), {5'b0, VECS[i].mode, 1'b0, VECS[i].inv, 23'b0});
         idle(5);
         wr(sts_a(int'(VECS[i].pin)), 32'd1 << (VECS[i].pin % 32));
         set_pin(int'(VECS[i].pin), VECS[i].post);
         idle(5);
         rd(sts_a(int'(VECS[i].pin)), d);
         chk($sformatf("R5/R6/R3/R4 vec%0d status", i), NP'(d[VECS[i].pin % 32]), NP'(VECS[i].exp));
         rd(cfg_a(int'(VECS[i].pin)), d);
         chk($sformatf("R2 vec%0d rx bit", i), NP'(d[1]), NP'(VECS[i].post));
      end

      // Fresh reset, R11
      @(negedge clk);
      rst_n = 1'b0; pad_in = '0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      rd(cfg_a(0), d);   chk("R11 cfg0 reset", NP'(d), '0);
      rd(12'h100, d);    chk("R11 status word0 reset", NP'(d), '0);
      rd(12'h108, d);    chk("R11 status word2 reset", NP'(d), '0);
      rd(12'h110, d);    chk("R8 enable reset", NP'(d), '0);
      chk("R11 pad_out reset", pad_out, '0);
      chk("R9 irq reset", NP'(irq), '0);

      // R1: writable bits and output drive
      wr(cfg_a(7), 32'hFFFF_FFFF);
      rd(cfg_a(7), d);   chk("R1 cfg writable bits", NP'(d), NP'(32'h0680_0001));
      chk("R1 pad_out drive", pad_out, NP'(1) << 7);
      wr(cfg_a(7), 32'h0);
      chk("R1 pad_out release", pad_out, '0);
      wr(12'h100, 32'hFFFF_FFFF);
      rd(12'h100, d);    chk("R7 clear all", NP'(d), '0);

      // R2: two-stage latency, bit not writable
      set_pin(12, 1'b1);
      rd(cfg_a(12), d);  chk("R2 rx after one edge", NP'(d[1]), '0);
      rd(cfg_a(12), d);  chk("R2 rx after two edges", NP'(d[1]), NP'(1));
      set_pin(12, 1'b0);
      wr(cfg_a(12), 32'h2);
      idle(4);
      rd(cfg_a(12), d);  chk("R2 rx write ignored", NP'(d), '0);
      wr(12'h100, 32'hFFFF_FFFF);

      // R7 / R8 / R9: W1C, masking and interrupt
      wr(cfg_a(3), 32'h0200_0000);
      set_pin(3, 1'b1);
      idle(5);
      rd(12'h100, d);    chk("R7 pad3 pending", NP'(d), NP'(32'h8));
      chk("R9 irq masked", NP'(irq), '0);
      wr(12'h100, 32'h0);
      rd(12'h100, d);    chk("R7 zero write no effect", NP'(d), NP'(32'h8));
      wr(12'h110, 32'h8);
      chk("R9 irq enabled", NP'(irq), NP'(1));
      rd(12'h110, d);    chk("R8 enable readback", NP'(d), NP'(32'h8));
      wr(12'h100, 32'h8);
      chk("R9 irq after clear", NP'(irq), '0);
      rd(12'h100, d);    chk("R7 one write clears", NP'(d), '0);

      // R4: clear during active level does not stick
      wr(cfg_a(10), 32'h0);
      set_pin(10, 1'b1);
      idle(5);
      wr(12'h100, 32'h400);
      idle(2);
      rd(12'h100, d);    chk("R4 level clear re-arms", NP'(d[10]), NP'(1));

      // R10: unmapped space
      rd(12'h604, d);    chk("R10 unaligned cfg reads 0", NP'(d), '0);
      wr(12'hB00, 32'hFFFF_FFFF);
      rd(12'hB00, d);    chk("R10 cfg beyond pins reads 0", NP'(d), '0);
      chk("R10 write beyond pins ignored", pad_out, '0);
      wr(12'h118, 32'hFFFF_FFFF);
      rd(12'h118, d);    chk("R10 enable absent bits 0", NP'(d), NP'(32'h0000_FFFF));
      rd(12'h10C, d);    chk("R10 status word beyond 0", NP'(d), '0);
      rd(12'h11C, d);    chk("R10 enable word beyond 0", NP'(d), '0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule